// File: doc/BRIEF.md
# Fetch-Gated ROM Read Guard

This block sits between an 8-bit processor and its memories on a bus with a 16-bit address. It keeps a single lock bit that decides whether data reads from the protected low ROM are allowed. The lock bit is set or cleared at each opcode fetch from the top address bit of that fetch. As a result, only code that runs from the lower half of the address space can read the protected ROM. Any I/O cycle locks the ROM again at once.

The block also turns the two top address bits into chip selects for three devices: the protected ROM, the RAM and the high ROM-backed region. It passes the processor's read and write strobes to the memories as internal copies. It then chooses what goes back on the read data path. A blocked read returns a fixed idle byte with the valid flag low. A read of the unmapped window returns the idle byte with the valid flag high.

The lock is a two-state machine with states ST_LOCKED and ST_OPEN. It has three named transitions:
- T_UNLOCK: ST_LOCKED to ST_OPEN, taken on a new fetch whose top address bit is 0.
- T_FETCH_HIGH: ST_OPEN to ST_LOCKED, taken on a new fetch whose top address bit is 1.
- T_IO: either state to ST_LOCKED, taken on any clock edge with the I/O request asserted. T_IO takes priority over a fetch on the same edge.

In every other case the state holds.

Top module: `fetch_rom_guard`

## Requirements
- R1: After reset the lock is in ST_LOCKED. A non-fetch read in 0000h–3FFFh (address top bits 00) then returns the idle byte with valid low, and the protected ROM select stays low.
- R2: A clock edge that first sees fetch and memory request both low, with address bit 15 at 0 and I/O request high, moves the lock to ST_OPEN. From the next cycle, non-fetch reads of top bits 00 return the protected ROM data with valid high.
- R3: A clock edge that first sees a fetch with address bit 15 at 1 moves the lock to ST_LOCKED, so later non-fetch reads of top bits 00 are blocked.
- R4: Any clock edge with the I/O request low moves the lock to ST_LOCKED, even when a fetch from the low half is seen on the same edge.
- R5: During a fetch cycle with address bit 15 at 0, the protected ROM is selected and its data returned with valid high, whatever the lock state.
- R6: While the memory request is low, the selects follow the address top bits: 00 selects the protected ROM (when permitted), 10 selects the RAM and 11 selects the high region. At most one select is high, and none is high while the memory request is high.
- R7: A read with top bits 01 (4000h–7FFFh) asserts no select and returns the idle byte with valid high.
- R8: Reads with top bits 10 and 11 return RAM and high-region data with valid high in either lock state.
- R9: A blocked protected read returns the idle byte (parameter, default FFh) with valid low and no select. When no memory read is in progress, the output is the idle byte with valid low.
- R10: The memory read strobe is low exactly when both the memory request and the processor read are low. The memory write strobe is low exactly when both the memory request and the processor write are low.
- R11: While a fetch stays asserted across several edges, only its first edge updates the lock. Later changes of address bit 15 during that fetch have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_n | input | 1 | Opcode-fetch strobe, active low |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| addr_hi | input | 2 | Address bits 15 and 14 |
| lowrom_data | input | 8 | Data from the protected ROM |
| ram_data | input | 8 | Data from the RAM |
| hirom_data | input | 8 | Data from the high region |
| cs_lowrom | output | 1 | Protected ROM select, active high |
| cs_ram | output | 1 | RAM select, active high |
| cs_hirom | output | 1 | High region select, active high |
| mem_rd_n | output | 1 | Read strobe copy sent to the memories |
| mem_wr_n | output | 1 | Write strobe copy sent to the memories |
| cpu_rdata | output | 8 | Data returned to the processor |
| cpu_rvalid | output | 1 | High when cpu_rdata carries device or open-bus data |

## Verification
The bench attacks the protection from several directions:
- **Fetch at 7FFFh.** A fetch from just below 8000h opens the lock, and a read then follows. A design that latched the wrong bit or inverted it would leak or block the ROM at the wrong times.
- **I/O on the same edge as a low fetch.** A design that gave the fetch priority would stay open after an I/O cycle.
- **Address change during a held fetch.** The address crosses 8000h while the fetch strobe stays low. A design that sampled at every edge instead of the first would flip the lock.
- **Opcode fetch while locked.** A fetch from the protected ROM while locked must still deliver the opcode.
- **Unmapped window.** Reads there must give the idle byte with valid high and no select.

A long constrained-random run checks every cycle against a bench model of the lock.

// File: rtl/fguard_pkg.sv
package fguard_pkg;

    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } lock_state_e;

    typedef enum logic [1:0] {
        RGN_LOWROM = 2'b00,
        RGN_GAP    = 2'b01,
        RGN_RAM    = 2'b10,
        RGN_HIROM  = 2'b11
    } region_e;

endpackage

// File: rtl/fguard_lock_fsm.sv
module fguard_lock_fsm
    import fguard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_n,
    input  logic mreq_n,
    input  logic iorq_n,
    input  logic addr_msb,
    output logic lock_open
);

    lock_state_e state_q, state_d;
    logic        fetch_now;
    logic        fetch_seen_q;
    logic        fetch_start;

    // An opcode fetch is active when both strobes are low.
    // fetch_seen_q remembers it so that only the first edge counts.
    assign fetch_now   = !fetch_n && !mreq_n;
    assign fetch_start = fetch_now && !fetch_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fetch_seen_q <= 1'b0;
        end else begin
            fetch_seen_q <= fetch_now;
        end
    end

    // Next-state logic.
    // T_IO has priority; T_UNLOCK and T_FETCH_HIGH need a new fetch.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (!iorq_n) begin
                    state_d = ST_LOCKED;              // T_IO
                end else if (fetch_start && !addr_msb) begin
                    state_d = ST_OPEN;                // T_UNLOCK
                end
            end
            ST_OPEN: begin
                if (!iorq_n) begin
                    state_d = ST_LOCKED;              // T_IO
                end else if (fetch_start && addr_msb) begin
                    state_d = ST_LOCKED;              // T_FETCH_HIGH
                end
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process.
    always_comb begin
        unique case (state_q)
            ST_OPEN: lock_open = 1'b1;
            default: lock_open = 1'b0;
        endcase
    end

    // R4
    io_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iorq_n |=> (state_q == ST_LOCKED));

    // R2
    fetch_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_start && !addr_msb && iorq_n) |=> (state_q == ST_OPEN));

    // R3
    fetch_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_start && addr_msb) |=> (state_q == ST_LOCKED));

    // R11
    held_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_now && fetch_seen_q && iorq_n) |=> $stable(state_q));

endmodule

// File: rtl/fguard_decode.sv
module fguard_decode
    import fguard_pkg::*;
#(
    parameter int REGION_BITS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [REGION_BITS-1:0] addr_hi,
    input  logic                   mreq_n,
    input  logic                   fetch_n,
    input  logic                   lock_open,
    output region_e                region,
    output logic                   low_permit,
    output logic                   cs_lowrom,
    output logic                   cs_ram,
    output logic                   cs_hirom
);

    localparam int MSB = REGION_BITS - 1;

    logic mem_cycle;

    assign mem_cycle = !mreq_n;
    assign region    = region_e'(addr_hi);

    // A fetch from the low half may always read its opcode;
    // any other protected access needs the lock open.
    assign low_permit = lock_open || (!fetch_n && !addr_hi[MSB]);

    always_comb begin
        cs_lowrom = 1'b0;
        cs_ram    = 1'b0;
        cs_hirom  = 1'b0;
        if (mem_cycle) begin
            unique case (region)
                RGN_LOWROM: cs_lowrom = low_permit;
                RGN_GAP:    ;
                RGN_RAM:    cs_ram    = 1'b1;
                RGN_HIROM:  cs_hirom  = 1'b1;
                default:    ;
            endcase
        end
    end

    // R6
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cs_lowrom, cs_ram, cs_hirom}));

    // R6
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_n |-> !(cs_lowrom || cs_ram || cs_hirom));

    // R7
    gap_nocs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_GAP) |-> !(cs_lowrom || cs_ram || cs_hirom));

endmodule

// File: rtl/fguard_rdmux.sv
module fguard_rdmux
    import fguard_pkg::*;
#(
    parameter int              DATA_W   = 8,
    parameter logic [DATA_W-1:0] IDLE_VAL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_active,
    input  region_e           region,
    input  logic              low_permit,
    input  logic [DATA_W-1:0] lowrom_data,
    input  logic [DATA_W-1:0] ram_data,
    input  logic [DATA_W-1:0] hirom_data,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    always_comb begin
        rdata  = IDLE_VAL;
        rvalid = 1'b0;
        if (rd_active) begin
            unique case (region)
                RGN_LOWROM: begin
                    if (low_permit) begin
                        rdata  = lowrom_data;
                        rvalid = 1'b1;
                    end
                end
                RGN_GAP: rvalid = 1'b1;
                RGN_RAM: begin
                    rdata  = ram_data;
                    rvalid = 1'b1;
                end
                RGN_HIROM: begin
                    rdata  = hirom_data;
                    rvalid = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R9
    blocked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && region == RGN_LOWROM && !low_permit)
            |-> (!rvalid && rdata == IDLE_VAL));

    // R8
    upper_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && (region == RGN_RAM || region == RGN_HIROM)) |-> rvalid);

endmodule

// File: rtl/fetch_rom_guard.sv
module fetch_rom_guard
    import fguard_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] IDLE_VAL = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_n,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [1:0]        addr_hi,
    input  logic [DATA_W-1:0] lowrom_data,
    input  logic [DATA_W-1:0] ram_data,
    input  logic [DATA_W-1:0] hirom_data,
    output logic              cs_lowrom,
    output logic              cs_ram,
    output logic              cs_hirom,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid
);

    localparam int REGION_BITS = 2;

    logic    lock_open;
    logic    low_permit;
    logic    rd_active;
    region_e region;

    // Internal copies of the strobes; nothing outside can override them.
    assign rd_active = !mreq_n && !rd_n;
    assign mem_rd_n  = !rd_active;
    assign mem_wr_n  = !(!mreq_n && !wr_n);

    fguard_lock_fsm u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_n   (fetch_n),
        .mreq_n    (mreq_n),
        .iorq_n    (iorq_n),
        .addr_msb  (addr_hi[REGION_BITS-1]),
        .lock_open (lock_open)
    );

    fguard_decode #(.REGION_BITS(REGION_BITS)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_hi    (addr_hi),
        .mreq_n     (mreq_n),
        .fetch_n    (fetch_n),
        .lock_open  (lock_open),
        .region     (region),
        .low_permit (low_permit),
        .cs_lowrom  (cs_lowrom),
        .cs_ram     (cs_ram),
        .cs_hirom   (cs_hirom)
    );

    fguard_rdmux #(.DATA_W(DATA_W), .IDLE_VAL(IDLE_VAL)) u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_active   (rd_active),
        .region      (region),
        .low_permit  (low_permit),
        .lowrom_data (lowrom_data),
        .ram_data    (ram_data),
        .hirom_data  (hirom_data),
        .rdata       (cpu_rdata),
        .rvalid      (cpu_rvalid)
    );

    // R10
    strobe_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_n) |-> (mem_rd_n && mem_wr_n));

    // R5
    low_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_n && !mreq_n && !rd_n && addr_hi == 2'b00)
            |-> (cs_lowrom && cpu_rvalid));

endmodule

// File: tb/fetch_rom_guard_bench.sv
module fetch_rom_guard_bench;

    localparam logic [7:0] IDLE = 8'hFF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fetch_n = 1'b1, mreq_n = 1'b1, iorq_n = 1'b1;
    logic       rd_n = 1'b1, wr_n = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic [7:0] lowrom_data = 8'h3C, ram_data = 8'h5A, hirom_data = 8'hA5;
    logic       cs_lowrom, cs_ram, cs_hirom, mem_rd_n, mem_wr_n, cpu_rvalid;
    logic [7:0] cpu_rdata;

    int checks = 0;
    int errors = 0;
    bit model_open = 1'b0;
    bit model_seen = 1'b0;

    always #2.5 clk = ~clk;

    fetch_rom_guard #(.DATA_W(8), .IDLE_VAL(IDLE)) u_fetch_rom_guard (
        .clk(clk), .rst_n(rst_n), .fetch_n(fetch_n), .mreq_n(mreq_n),
        .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .addr_hi(addr[15:14]),
        .lowrom_data(lowrom_data), .ram_data(ram_data), .hirom_data(hirom_data),
        .cs_lowrom(cs_lowrom), .cs_ram(cs_ram), .cs_hirom(cs_hirom),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid)
    );

    function automatic bit exp_permit();
        return model_open || (!fetch_n && !addr[15]);
    endfunction

    // {cs_lowrom, cs_ram, cs_hirom, mem_rd_n, mem_wr_n, rvalid, rdata}
    function automatic logic [13:0] exp_outs();
        bit mem = !mreq_n;
        bit rd  = mem && !rd_n;
        logic [1:0] rg = addr[15:14];
        logic [7:0] d = IDLE;
        bit v = 1'b0;
        if (rd) begin
            case (rg)
                2'b00: if (exp_permit()) begin d = lowrom_data; v = 1'b1; end
                2'b01: v = 1'b1;
                2'b10: begin d = ram_data; v = 1'b1; end
                default: begin d = hirom_data; v = 1'b1; end
            endcase
        end
        return {mem && rg == 2'b00 && exp_permit(), mem && rg == 2'b10,
                mem && rg == 2'b11, !rd, !(mem && !wr_n), v, d};
    endfunction

    function automatic string tag_for();
        case (addr[15:14])
            2'b00: return exp_permit() ? "R2 R5" : "R1 R9";
            2'b01: return "R7";
            default: return "R6 R8";
        endcase
    endfunction

    task automatic check_outs(input string tag);
        logic [13:0] got, exp;
        got = {cs_lowrom, cs_ram, cs_hirom, mem_rd_n, mem_wr_n, cpu_rvalid, cpu_rdata};
        exp = exp_outs();
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s addr=%h: got %b expected %b (R10 strobes included)",
                     tag, addr, got, exp);
        end
    endtask

    // Drive after a falling edge, check, then advance the model at the rising edge.
    task automatic step(input bit f, input bit m, input bit io, input bit r,
                        input bit w, input logic [15:0] a, input string tag);
        @(negedge clk);
        fetch_n = f; mreq_n = m; iorq_n = io; rd_n = r; wr_n = w; addr = a;
        lowrom_data = 8'($urandom); ram_data = 8'($urandom); hirom_data = 8'($urandom);
        #1;
        check_outs(tag == "" ? tag_for() : tag);
        @(posedge clk);
        if (!iorq_n) model_open = 1'b0;
        else if (!fetch_n && !mreq_n && !model_seen) model_open = !addr[15];
        model_seen = !fetch_n && !mreq_n;
    endtask

    task automatic expect_open(input bit want, input string tag);
        // probe the lock through a plain read of the protected region
        step(1, 0, 1, 0, 1, 16'h0123, tag);
        checks++;
        if (cpu_rvalid !== want) begin
            errors++;
            $display("FAIL %s lock probe: got valid=%b expected %b", tag, cpu_rvalid, want);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state: locked, idle outputs
        step(1, 1, 1, 1, 1, 16'h0000, "R1");
        expect_open(1'b0, "R1");
        // R5 fetch from low ROM while locked still returns the opcode
        step(0, 0, 1, 0, 1, 16'h7FFF, "R5");
        // R2 the fetch at 7FFFh above opened the lock
        expect_open(1'b1, "R2");
        // R7 unmapped window
        step(1, 0, 1, 0, 1, 16'h4000, "R7");
        // R8 upper regions
        step(1, 0, 1, 0, 1, 16'h8000, "R8");
        step(1, 0, 1, 0, 1, 16'hC000, "R8");
        // R10 write strobe copy
        step(1, 0, 1, 1, 0, 16'h8001, "R10");
        step(1, 1, 1, 1, 0, 16'h8001, "R10");
        // R3 fetch from the high half locks
        step(0, 0, 1, 0, 1, 16'h8000, "R3");
        expect_open(1'b0, "R3");
        // R8 high region still readable while locked
        step(1, 0, 1, 0, 1, 16'hFFFF, "R8");
        // R4 I/O on the same edge as a low fetch wins
        step(0, 0, 1, 0, 1, 16'h0100, "R2");
        expect_open(1'b1, "R2");
        step(0, 0, 0, 0, 1, 16'h0000, "R4");
        expect_open(1'b0, "R4");
        // R11 held fetch: first edge opens, later A15 change ignored
        step(0, 0, 1, 0, 1, 16'h0010, "R11");
        step(0, 0, 1, 0, 1, 16'h9000, "R11");
        expect_open(1'b1, "R11");
        // R11 held fetch in other direction
        step(0, 0, 1, 0, 1, 16'hC000, "R11");
        step(0, 0, 1, 0, 1, 16'h0000, "R11");
        expect_open(1'b0, "R11");
        // R9 no read in progress: idle byte, valid low
        step(1, 1, 1, 1, 1, 16'h8000, "R9");
        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            bit io = ($urandom_range(0, 15) != 0);
            bit m  = io ? ($urandom_range(0, 3) == 0) : 1'b1;
            bit f  = m ? 1'b1 : ($urandom_range(0, 2) != 0);
            bit r  = $urandom_range(0, 1);
            bit w  = r ? $urandom_range(0, 1) : 1'b1;
            step(f, m, io, r, w, 16'($urandom), "");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule